// File: doc/BRIEF.md
# Command-Word Watchdog Timer

A watchdog timer for a system-on-chip that software drives through two 32-bit memory-mapped registers. The first is a command register. Software writes one of a few fixed 16-bit codes to it to stop or restart the countdown, clear the pending interrupt, open or close write access to the count register, or reload the counter with its largest value. The second register holds a 16-bit window onto a 20-bit down-counter. That counter decrements once for each pulse of a slow timebase tick.

In normal use, software opens the count register, writes a timeout, closes the register and starts the timer. It then either keeps reloading the count before it runs out, or issues the maximum-reload command. If the counter runs down to zero, the block raises a sticky interrupt flag and a one-cycle reset request for the system reset controller. Software can force an almost immediate reset by loading a count of 1 and starting the timer.

Top module: `wdg_magic_timer`

## Requirements
- R1: After reset the timer is stopped, the count register reads 0x0000FFFF, `irq` and `rstReq` are low, and the count register is closed to writes.
- R2: The command register is at byte offset 0x0 and the count register at 0x4. A read at 0x4 returns counter bits [19:4] in bits [15:0], with zeros above them. A read at any other offset returns zero.
- R3: While running, the counter drops by one on each clock edge where `tick` is high and the counter is non-zero. While stopped, `tick` has no effect.
- R4: Command 0x3877 stops the count, which then stays frozen. Command 0x4A4B restarts it from the frozen value.
- R5: Command 0xAB00 opens the count register. A write to offset 0x4 then loads counter bits [19:4] from data bits [15:0] and clears bits [3:0]. Data bits [31:16] are ignored. Command 0xAB01 closes the register again.
- R6: A write to the count register while it is closed leaves the counter unchanged.
- R7: Command 0xDEAF loads 0xFFFFF into the counter, whether the count register is open or closed.
- R8: When a decrement takes the counter from 1 to 0, `irq` goes high and stays high. `rstReq` is high for exactly the next cycle. The counter then holds at zero until it is reloaded.
- R9: Command 0x7482 clears `irq`. If an expiry occurs in the same cycle, the expiry wins and `irq` stays high.
- R10: A write to offset 0x0 is a command only if bits [31:16] are zero and bits [15:0] equal one of the six codes. Any other write there, and any write to an unused offset, changes no state.
- R11: A count load or a maximum reload in the same cycle as a tick replaces the decrement, and no expiry occurs in that cycle.
- R12: Loading a count of 1 and starting the timer leads to expiry on the 16th tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe, one clock wide per decrement |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Sticky expiry flag |
| rstReq | output | 1 | One-cycle registered system reset request |

## Verification
The assertions assume that each write lasts one clock and that `tick` is sampled only at clock edges. They also assume that `addr` and `wrData` are stable around the edge where `wrEn` is high. The bench changes every input half a cycle away from the rising edge and holds each write for exactly one cycle. Random count loads are kept to small values so that expiry, the hold at zero and clear-versus-expiry collisions happen often. Command words are drawn mostly from the valid set, mixed with random words and words whose upper bits are non-zero.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CMD_W  = 16;
  localparam int CNT_W  = 20;
  localparam int WIN_W  = 16;

  localparam logic [ADDR_W-1:0] CTRL_OFF = 4'h0;
  localparam logic [ADDR_W-1:0] CNT_OFF  = 4'h4;

  localparam logic [CMD_W-1:0] CMD_HALT   = 16'h3877;
  localparam logic [CMD_W-1:0] CMD_GO     = 16'h4A4B;
  localparam logic [CMD_W-1:0] CMD_ACK    = 16'h7482;
  localparam logic [CMD_W-1:0] CMD_OPEN   = 16'hAB00;
  localparam logic [CMD_W-1:0] CMD_CLOSE  = 16'hAB01;
  localparam logic [CMD_W-1:0] CMD_REFILL = 16'hDEAF;

  typedef struct packed {
    logic loadMax;
    logic loadWin;
    logic count;
    logic clrIrq;
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_cmd_ctrl.sv
module wdg_cmd_ctrl
  import wdg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CMD_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output wdgStrobe_t    strb
);
  localparam int HI_W = DW - CW;

  logic          running;
  logic          unlocked;
  logic          ctrlHit;
  logic          cntHit;
  logic          upperClear;
  logic [CW-1:0] cmd;
  logic          isHalt, isGo, isAck, isOpen, isClose, isRefill, isKnown;

  assign cmd        = wrData[CW-1:0];
  assign upperClear = (wrData[DW-1:CW] == {HI_W{1'b0}});
  assign ctrlHit    = wrEn && (addr == AW'(CTRL_OFF)) && upperClear;
  assign cntHit     = wrEn && (addr == AW'(CNT_OFF));

  always_comb begin
    isHalt   = ctrlHit && (cmd == CMD_HALT);
    isGo     = ctrlHit && (cmd == CMD_GO);
    isAck    = ctrlHit && (cmd == CMD_ACK);
    isOpen   = ctrlHit && (cmd == CMD_OPEN);
    isClose  = ctrlHit && (cmd == CMD_CLOSE);
    isRefill = ctrlHit && (cmd == CMD_REFILL);
    isKnown  = isHalt || isGo || isAck || isOpen || isClose || isRefill;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (isHalt)     running  <= 1'b0;
      else if (isGo)  running  <= 1'b1;
      if (isOpen)     unlocked <= 1'b1;
      else if (isClose) unlocked <= 1'b0;
    end
  end

  always_comb begin
    strb.loadMax = isRefill;
    strb.loadWin = cntHit && unlocked;
    strb.count   = running && tick;
    strb.clrIrq  = isAck;
  end

  // R4
  run_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(wrEn && addr == AW'(CTRL_OFF) && wrData == DW'(CMD_GO)));

  // R5
  open_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(wrEn && addr == AW'(CTRL_OFF) && wrData == DW'(CMD_OPEN)));

  // R10
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AW'(CTRL_OFF) && !isKnown) |=> ($stable(running) && $stable(unlocked)));

  // R6
  closed_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && !$rose(unlocked)) |-> !strb.loadWin);
endmodule

// File: rtl/wdg_count_path.sv
module wdg_count_path
  import wdg_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int WW = WIN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdgStrobe_t    strb,
  input  logic [WW-1:0] winVal,
  output logic [WW-1:0] cntWin,
  output logic          irq,
  output logic          rstReq
);
  localparam int SHIFT = CW - WW;

  logic [CW-1:0] cnt;
  logic          anyLoad;
  logic          expire;

  assign anyLoad = strb.loadMax || strb.loadWin;
  assign expire  = strb.count && !anyLoad && (cnt == CW'(1));
  assign cntWin  = cnt[CW-1:SHIFT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= {CW{1'b1}};
    end else if (strb.loadMax) begin
      cnt <= {CW{1'b1}};
    end else if (strb.loadWin) begin
      cnt <= {winVal, {SHIFT{1'b0}}};
    end else if (strb.count && (cnt != '0)) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq    <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= expire;
      if (expire)           irq <= 1'b1;
      else if (strb.clrIrq) irq <= 1'b0;
    end
  end

  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.count && !anyLoad) |=> $stable(cnt));

  // R3
  no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoad |=> (cnt <= $past(cnt)));

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R8
  req_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> irq);

  // R8
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !anyLoad) |=> (cnt == '0));

  // R9
  ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrIrq && !strb.count) |=> !irq);
endmodule

// File: rtl/wdg_magic_timer.sv
module wdg_magic_timer
  import wdg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int CW = CNT_W,
  parameter int WW = WIN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          irq,
  output logic          rstReq
);
  wdgStrobe_t    strb;
  logic [WW-1:0] cntWin;

  wdg_cmd_ctrl #(.DW(DW), .AW(AW), .CW(CMD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .strb(strb)
  );

  wdg_count_path #(.CW(CW), .WW(WW)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .winVal(wrData[WW-1:0]),
    .cntWin(cntWin), .irq(irq), .rstReq(rstReq)
  );

  assign rdData = (addr == AW'(CNT_OFF)) ? DW'(cntWin) : '0;

  // R2
  read_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr != AW'(CNT_OFF)) |-> (rdData == '0));
endmodule

// File: tb/tb_wdg_magic_timer.sv
module tb_wdg_magic_timer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        tick;
  logic        wrEn;
  logic [3:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        irq;
  logic        rstReq;

  always #10 clk = ~clk;

  wdg_magic_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .rstReq(rstReq)
  );

  logic [19:0] mCnt;
  logic        mRun, mUnl, mIrq, mReq;
  int          totalCnt = 0;
  int          failCnt = 0;
  bit          done = 1'b0;

  function automatic bit isCmd(input logic [31:0] d, input logic [15:0] code);
    return d == {16'h0, code};
  endfunction

  task automatic modelStep(input logic w, input logic [3:0] a,
                           input logic [31:0] d, input logic t);
    logic ldMax, ldWin, ack, exp;
    logic nRun, nUnl;
    nRun = mRun; nUnl = mUnl;
    ldMax = 0; ldWin = 0; ack = 0;
    if (w && a == 4'h0) begin
      if (isCmd(d, 16'h3877)) nRun = 0;
      if (isCmd(d, 16'h4A4B)) nRun = 1;
      if (isCmd(d, 16'h7482)) ack = 1;
      if (isCmd(d, 16'hAB00)) nUnl = 1;
      if (isCmd(d, 16'hAB01)) nUnl = 0;
      if (isCmd(d, 16'hDEAF)) ldMax = 1;
    end
    if (w && a == 4'h4 && mUnl) ldWin = 1;
    exp = !ldMax && !ldWin && mRun && t && (mCnt == 20'd1);
    if (ldMax) mCnt = 20'hFFFFF;
    else if (ldWin) mCnt = {d[15:0], 4'h0};
    else if (mRun && t && mCnt != 0) mCnt = mCnt - 1;
    if (exp) mIrq = 1;
    else if (ack) mIrq = 0;
    mReq = exp;
    mRun = nRun; mUnl = nUnl;
  endtask

  task automatic checkPorts(input string tag);
    totalCnt++;
    if (rdData !== {16'h0, mCnt[19:4]} || irq !== mIrq || rstReq !== mReq) begin
      failCnt++;
      $display("FAIL %s: actual rd=%h irq=%b req=%b expected rd=%h irq=%b req=%b",
               tag, rdData, irq, rstReq, {16'h0, mCnt[19:4]}, mIrq, mReq);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic t, input string tag);
    wrEn = w; addr = a; wrData = d; tick = t;
    modelStep(w, a, d, t);
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; tick = 0; addr = 4'h4; wrData = 0;
    #1;
    checkPorts(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL R1 watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rstN = 0; tick = 0; wrEn = 0; addr = 4'h4; wrData = 0;
    mCnt = 20'hFFFFF; mRun = 0; mUnl = 0; mIrq = 0; mReq = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    checkPorts("R1 reset state");
    addr = 4'h0; #1;
    totalCnt++;
    if (rdData !== 32'h0) begin
      failCnt++;
      $display("FAIL R2 control read: actual %h expected 0", rdData);
    end
    addr = 4'h8; #1;
    totalCnt++;
    if (rdData !== 32'h0) begin
      failCnt++;
      $display("FAIL R2 unused read: actual %h expected 0", rdData);
    end
    addr = 4'h4; #1;

    step(0, 4'h4, 0, 1, "R3 tick while stopped");
    step(1, 4'h4, 32'h5, 0, "R6 closed after reset");
    step(1, 4'h0, 32'hAB00, 0, "R5 open");
    step(1, 4'h4, 32'hFFFF_0002, 0, "R5 load window");
    step(1, 4'h0, 32'hAB01, 0, "R5 close");
    step(1, 4'h4, 32'h7, 0, "R6 closed write");
    step(1, 4'h0, 32'h4A4B, 0, "R4 go");
    for (int i = 0; i < 20; i++) step(0, 4'h4, 0, 1, "R3 decrement");
    step(1, 4'h0, 32'h3877, 1, "R4 halt");
    step(0, 4'h4, 0, 1, "R4 frozen");
    step(1, 4'h0, 32'h1234, 0, "R10 bad code");
    step(1, 4'h0, 32'h0001_4A4B, 0, "R10 upper bits set");
    step(0, 4'h4, 0, 1, "R10 still halted");
    step(1, 4'h0, 32'h4A4B, 0, "R4 resume");
    step(0, 4'h4, 0, 1, "R4 continues");
    step(1, 4'h0, 32'hAB00, 0, "R12 open");
    step(1, 4'h4, 32'h1, 1, "R11 load beats tick");
    for (int i = 0; i < 15; i++) step(0, 4'h4, 0, 1, "R12 countdown");
    step(0, 4'h4, 0, 1, "R8 expiry");
    step(0, 4'h4, 0, 1, "R8 pulse end and hold");
    step(1, 4'h0, 32'h7482, 0, "R9 ack");
    step(1, 4'h4, 32'h1, 0, "R9 reload");
    for (int i = 0; i < 15; i++) step(0, 4'h4, 0, 1, "R9 countdown");
    step(1, 4'h0, 32'h7482, 1, "R9 expiry beats ack");
    step(1, 4'h0, 32'hAB01, 0, "R7 close");
    step(1, 4'h0, 32'hDEAF, 1, "R7 refill while closed");
    step(1, 4'h8, 32'hAB00, 0, "R10 unused offset");
    step(1, 4'h4, 32'h3, 0, "R6 still closed");

    for (int n = 0; n < 1500; n++) begin
      int unsigned r;
      logic [31:0] d;
      logic [3:0]  a;
      logic        w;
      r = $urandom % 10;
      w = 1; a = 4'h0; d = 0;
      if (r < 4) begin
        case ($urandom % 8)
          0: d = 32'h3877;
          1: d = 32'h4A4B;
          2: d = 32'h7482;
          3: d = 32'hAB00;
          4: d = 32'hAB01;
          5: d = 32'hDEAF;
          default: d = $urandom;
        endcase
        if ($urandom % 8 == 0) d = d | 32'h0002_0000;
      end else if (r < 7) begin
        a = 4'h4;
        d = ($urandom & 32'hFFFF_0000) | ($urandom % 4);
      end else if (r < 8) begin
        a = 4'hC;
        d = $urandom;
      end else begin
        w = 0;
      end
      step(w, a, d, ($urandom % 4) != 0, "R3,R8,R9,R11 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule